// File: doc/BRIEF.md
# Serial Channel Bit-Rate Generator

This block produces the timing strobes that pace one serial channel. A programmable 8-bit divisor and a power-of-four prescaler split the peripheral clock into a base clock. The block then counts base-clock periods to mark bit boundaries. The number of base periods per bit depends on the channel mode:

- asynchronous, with a choice of 16 or 8 base periods per bit;
- clock synchronous, at 2 base periods per bit;
- smart card, with a selectable periods-per-etu factor.

In asynchronous mode a mid-bit strobe is also produced, which a receiver uses to sample.

Software loads the divisor through a simple write port, and the current value can always be read back. Loading is refused while the transmitter or the receiver is enabled, so the bit period cannot change under a running transfer. While both enables are low, every counter is held at zero. The first cycle in which either enable rises therefore starts counting from a known phase.

Top module: `bitrate_gen`

## Requirements
- R1: After reset the divisor reads 8'hFF, and `rd_data` always shows the stored divisor.
- R2: A write (`wr_en` high for one cycle) stores `wr_data` only if `tx_en` and `rx_en` are both 0; otherwise the stored divisor is unchanged.
- R3: With clock select c (0..3) and divisor N, `base_tick` pulses once every P2 = 2·4^c·(N+1) cycles. Its first pulse comes in cycle P2−1, counting from 0 at the first enabled cycle.
- R4: In asynchronous mode (`mode_sel`=00), `bit_tick` pulses every 16 base periods when `half_base`=0 and every 8 base periods when `half_base`=1. The first pulse is in cycle K·P2−1, where K is the base periods per bit.
- R5: In clock synchronous mode (`mode_sel`=01), `bit_tick` pulses every 2 base periods, and every `bit_tick` coincides with a `base_tick`.
- R6: In smart card mode (`mode_sel`=10 or 11), `bit_tick` pulses every S base periods. The code `etu_sel` maps 000→32, 001→64, 010→372 and 011→256; every other code gives 372.
- R7: `mid_tick` pulses only in asynchronous mode, on the base tick that ends base period K/2 of each bit (cycle K·P2/2−1 for the first bit). It never pulses in the other modes.
- R8: While `tx_en` and `rx_en` are both 0, no strobe pulses. Re-enabling restarts all timing from phase zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divisor write strobe |
| wr_data | input | 8 | Divisor value to write |
| rd_data | output | 8 | Stored divisor |
| tx_en | input | 1 | Transmitter enable level |
| rx_en | input | 1 | Receiver enable level |
| mode_sel | input | 2 | 00 async, 01 clock synchronous, 1x smart card |
| half_base | input | 1 | Async: 1 selects 8 base periods per bit, 0 selects 16 |
| clk_sel | input | 2 | Prescaler select: divide by 4^clk_sel |
| etu_sel | input | 3 | Smart card periods-per-etu code |
| base_tick | output | 1 | One-cycle strobe per base-clock period |
| bit_tick | output | 1 | One-cycle strobe at each bit boundary |
| mid_tick | output | 1 | One-cycle mid-bit strobe (async only) |

## Verification
The assertions check these rules on every cycle:

- the write lock and write acceptance on the divisor;
- silence of all strobes while the channel is disabled;
- every bit strobe landing on a base strobe;
- the mid-bit strobe appearing only in asynchronous mode and never on a bit boundary.

The bench scenarios are the only way to show the actual cycle counts, because those come from the product of prescaler, divisor and per-mode factor. Those counts include:

- the base and bit periods;
- the smart card code mapping, including the fallback codes;
- the position of the mid-bit strobe;
- the restart from phase zero after the enables drop.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned PRE_W = 6;
  localparam int unsigned BIT_W = 9;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_SC0   = 2'b10,
    MODE_SC1   = 2'b11
  } chan_mode_e;

  function automatic logic [BIT_W-1:0] etu_periods(input logic [2:0] code);
    case (code)
      3'b000:  etu_periods = BIT_W'(32);
      3'b001:  etu_periods = BIT_W'(64);
      3'b011:  etu_periods = BIT_W'(256);
      default: etu_periods = BIT_W'(372);
    endcase
  endfunction

  function automatic logic [BIT_W-1:0] periods_per_bit(input logic [1:0] mode,
                                                       input logic half,
                                                       input logic [2:0] code);
    case (mode)
      MODE_ASYNC: periods_per_bit = half ? BIT_W'(8) : BIT_W'(16);
      MODE_SYNC:  periods_per_bit = BIT_W'(2);
      default:    periods_per_bit = etu_periods(code);
    endcase
  endfunction
endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int unsigned PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d, limit;
  logic             cnt_en;

  always_comb begin
    case (sel)
      2'd0:    limit = PRE_W'(0);
      2'd1:    limit = PRE_W'(3);
      2'd2:    limit = PRE_W'(15);
      default: limit = PRE_W'(63);
    endcase
  end

  assign tick = run && (cnt_q == limit);

  always_comb begin
    cnt_en = 1'b1;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bg_divider.sv
module bg_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] divisor,
  output logic             base_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             half_tick, cnt_en;

  assign half_tick = step && (cnt_q == divisor);
  assign base_tick = half_tick && phase_q;

  always_comb begin
    cnt_en  = step || !run;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (half_tick) begin
      cnt_d   = '0;
      phase_d = !phase_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/bg_bitcnt.sv
module bg_bitcnt #(
  parameter int unsigned BIT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             base_tick,
  input  logic [BIT_W-1:0] per_bit,
  input  logic             mid_en,
  output logic             bit_tick,
  output logic             mid_tick
);
  logic [BIT_W-1:0] cnt_q, cnt_d, last, mid_at;
  logic             cnt_en;

  assign last     = per_bit - BIT_W'(1);
  assign mid_at   = (per_bit >> 1) - BIT_W'(1);
  assign bit_tick = base_tick && (cnt_q == last);
  assign mid_tick = base_tick && mid_en && (cnt_q == mid_at);

  always_comb begin
    cnt_en = base_tick || !run;
    if (!run)          cnt_d = '0;
    else if (bit_tick) cnt_d = '0;
    else               cnt_d = cnt_q + BIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
  import bg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] rd_data,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [1:0]       mode_sel,
  input  logic             half_base,
  input  logic [1:0]       clk_sel,
  input  logic [2:0]       etu_sel,
  output logic             base_tick,
  output logic             bit_tick,
  output logic             mid_tick
);
  logic             run, pre_tick, div_load, mid_en;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] per_bit;

  assign run      = tx_en || rx_en;
  assign div_load = wr_en && !run;
  assign rd_data  = div_q;
  assign per_bit  = periods_per_bit(mode_sel, half_base, etu_sel);
  assign mid_en   = (mode_sel == MODE_ASYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '1;
    else if (div_load) div_q <= wr_data;
  end

  bg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(clk_sel), .tick(pre_tick)
  );

  bg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .step(pre_tick),
    .divisor(div_q), .base_tick(base_tick)
  );

  bg_bitcnt #(.BIT_W(BIT_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .run(run), .base_tick(base_tick),
    .per_bit(per_bit), .mid_en(mid_en),
    .bit_tick(bit_tick), .mid_tick(mid_tick)
  );
endmodule

// File: rtl/bitrate_gen_chk.sv
module bitrate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       tx_en,
  input logic       rx_en,
  input logic [1:0] mode_sel,
  input logic       base_tick,
  input logic       bit_tick,
  input logic       mid_tick
);
  a_r2_write_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (tx_en || rx_en)) |=> $stable(rd_data));

  a_r2_write_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_en && !rx_en) |=> (rd_data == $past(wr_data)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !rx_en) |-> (!base_tick && !bit_tick && !mid_tick));

  a_r5_bit_on_base: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_tick);

  a_r7_mid_async_only: assert property (@(posedge clk) disable iff (!rst_n)
    mid_tick |-> (base_tick && !bit_tick && mode_sel == 2'b00));
endmodule

bind bitrate_gen bitrate_gen_chk u_chk (.*);

// File: tb/bitrate_gen_bench.sv
module bitrate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       tx_en, rx_en;
  logic [1:0] mode_sel;
  logic       half_base;
  logic [1:0] clk_sel;
  logic [2:0] etu_sel;
  logic       base_tick, bit_tick, mid_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bitrate_gen u_bitrate_gen (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_k(input int mode, input int half, input int code);
    if (mode == 0) return half ? 8 : 16;
    if (mode == 1) return 2;
    case (code)
      0: return 32;
      1: return 64;
      3: return 256;
      default: return 372;
    endcase
  endfunction

  function automatic int exp_p2(input int cs, input int n);
    return 2 * (1 << (2 * cs)) * (n + 1);
  endfunction

  task automatic write_div(input int v);
    wr_en = 1'b1; wr_data = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Runs one configuration over two bit periods and checks strobe timing.
  task automatic run_case(input int n, input int cs, input int mode,
                          input int half, input int code, input bit use_rx);
    int k, p2, lim, fb, fbit, sbit, fmid, nbase, nbit, nmid;
    tx_en = 1'b0; rx_en = 1'b0;
    write_div(n);
    check("R2", "divisor loaded while idle", int'(rd_data), n);
    mode_sel = 2'(mode); half_base = 1'(half); clk_sel = 2'(cs); etu_sel = 3'(code);
    k = exp_k(mode, half, code);
    p2 = exp_p2(cs, n);
    lim = 2 * k * p2;
    fb = -1; fbit = -1; sbit = -1; fmid = -1; nbase = 0; nbit = 0; nmid = 0;
    if (use_rx) rx_en = 1'b1; else tx_en = 1'b1;
    for (int idx = 0; idx < lim; idx++) begin
      #1;
      if (base_tick) begin nbase++; if (fb < 0) fb = idx; end
      if (bit_tick) begin
        nbit++;
        if (fbit < 0) fbit = idx; else if (sbit < 0) sbit = idx;
      end
      if (mid_tick) begin nmid++; if (fmid < 0) fmid = idx; end
      @(negedge clk);
    end
    check("R3", "first base strobe cycle", fb, p2 - 1);
    check("R3", "base strobes in two bits", nbase, 2 * k);
    if (mode == 0) check("R4", "async first bit strobe", fbit, k * p2 - 1);
    else if (mode == 1) check("R5", "sync first bit strobe", fbit, k * p2 - 1);
    else check("R6", "smart card first bit strobe", fbit, k * p2 - 1);
    check("R4", "second bit strobe cycle", sbit, 2 * k * p2 - 1);
    if (mode == 0) begin
      check("R7", "first mid strobe cycle", fmid, k * p2 / 2 - 1);
      check("R7", "mid strobes in two bits", nmid, 2);
    end else begin
      check("R7", "no mid strobe outside async", nmid, 0);
    end
    tx_en = 1'b0; rx_en = 1'b0;
  endtask

  initial begin
    int seen;
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tx_en = 1'b0; rx_en = 1'b0;
    mode_sel = 2'b00; half_base = 1'b0; clk_sel = 2'b00; etu_sel = 3'b000;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "divisor reset value", int'(rd_data), 255);
    check("R8", "no strobe in reset state", int'({base_tick, bit_tick, mid_tick}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: idle hold, strobes stay quiet for many cycles
    write_div(0);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      #1; if (base_tick || bit_tick || mid_tick) seen++;
      @(negedge clk);
    end
    check("R8", "strobes while idle", seen, 0);

    // R2: writes ignored while either enable is high
    write_div(8'h3C);
    tx_en = 1'b1; write_div(8'hA5); #1;
    check("R2", "write ignored with tx_en", int'(rd_data), 8'h3C);
    tx_en = 1'b0; rx_en = 1'b1; @(negedge clk); write_div(8'h5A); #1;
    check("R2", "write ignored with rx_en", int'(rd_data), 8'h3C);
    rx_en = 1'b0; @(negedge clk);

    // Directed corners
    run_case(0, 0, 0, 0, 0, 0);   // R4 fastest 16x
    run_case(0, 0, 0, 1, 0, 1);   // R4 8x
    run_case(1, 1, 1, 0, 0, 0);   // R5 sync
    run_case(0, 0, 2, 0, 0, 0);   // R6 S=32
    run_case(0, 0, 3, 0, 1, 1);   // R6 S=64
    run_case(0, 0, 2, 0, 2, 0);   // R6 S=372
    run_case(0, 0, 2, 0, 3, 0);   // R6 S=256
    run_case(0, 0, 3, 0, 5, 0);   // R6 fallback code
    run_case(1, 0, 2, 0, 7, 1);   // R6 fallback code
    run_case(7, 2, 0, 0, 0, 0);   // R3 prescaler /16
    run_case(0, 3, 1, 0, 0, 0);   // R3 prescaler /64

    // R8: partial run, drop enables, restart phase zero
    write_div(2); mode_sel = 2'b01; clk_sel = 2'b00;
    tx_en = 1'b1; repeat (7) @(negedge clk); tx_en = 1'b0; @(negedge clk);
    run_case(2, 0, 1, 0, 0, 0);

    // Constrained random
    for (int t = 0; t < 20; t++) begin
      int m, n, cs, h, c;
      m = int'($urandom_range(0, 3));
      h = int'($urandom_range(0, 1));
      c = int'($urandom_range(0, 7));
      if (m >= 2) begin n = int'($urandom_range(0, 1)); cs = 0; end
      else begin n = int'($urandom_range(0, 7)); cs = int'($urandom_range(0, 2)); end
      run_case(n, cs, m, h, c, 1'(t[0]));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule